// File: doc/BRIEF.md
# Layer Window Alpha Blender

This block merges one graphics layer onto the pixel stream beneath it. For each pixel it takes the screen counter position from the timing generator, a raw layer pixel and the lower pixel (either a lower layer's result or the background colour). If the layer is switched on and the position falls inside a programmed rectangle, the layer pixel is first decoded to 8-bit ARGB and then mixed with the lower pixel using two selectable blend factors. Everywhere else the lower pixel passes through untouched.

Indexed 8-bit pixels can be resolved through a 256-entry colour table. Software loads the table one entry at a time with a single word that carries both the entry index and the colour. Window limits are given in the counter space of the timing generator, so they already include the accumulated back porch: a limit equals the pixel position plus one plus that porch. Both limits are inclusive.

Results leave two clock cycles after the pixel enters. The alpha and blend-factor settings are read in the second stage, so they should be changed only while no pixel is in flight.

Top module: `lwb_top`

## Requirements
- R1: While reset is high, and on the first clock edge after it, `out_valid` is 0 and `out_pix` is 0.
- R2: `out_valid` repeats `pix_valid` exactly two clock edges later. `out_pix` holds its value while `out_valid` is low.
- R3: When `cfg_layer_on` is 0, each result equals the `lower_pix` that entered with it.
- R4: The layer applies only when `win_x_lo <= pos_x <= win_x_hi` and `win_y_lo <= pos_y <= win_y_hi`, with both bounds inclusive. Outside that rectangle the result equals `lower_pix`.
- R5: `cfg_fmt` decodes the layer pixel as follows. Code 0 is ARGB8888 (A in 31:24, R in 23:16, G in 15:8, B in 7:0). Code 1 is RGB888 in 23:0 with alpha 0xFF. Code 2 is RGB565 (R 15:11, G 10:5, B 4:0) with alpha 0xFF. Code 3 is ARGB1555 (A in bit 15, which gives 0xFF or 0x00; R 14:10, G 9:5, B 4:0). Code 4 is ARGB4444 (A 15:12, R 11:8, G 7:4, B 3:0). A field narrower than 8 bits is widened by repeating its top bits below it. Codes 6 and 7 decode as code 0.
- R6: Code 5 is an indexed 8-bit pixel taken from bits 7:0, with alpha 0xFF. When `cfg_clut_on` is 1, its RGB comes from the colour table. When `cfg_clut_on` is 0, the index is used as a grey level on all three channels. A table write (`tbl_wr` high) stores bits 23:16 as red, 15:8 as green and 7:0 as blue, at the entry given by bits 31:24.
- R7: Layer factor F1: code 6 selects round(PA×CA/255); every other code (4 is the usual one) selects CA.
- R8: Lower factor F2: code 7 selects 255 − round(PA×CA/255); every other code (5 is the usual one) selects 255 − CA.
- R9: Each output channel is (F1×layer + F2×lower + 127) / 255 using integer division, saturated to 255. The same rounding applies to the PA×CA product. Red sits in out_pix 23:16, green in 15:8 and blue in 7:0.
- R10: With CA = 0xFF, F1 code 4 and F2 code 5, an opaque pixel inside the window comes out exactly equal to the decoded layer colour.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_layer_on | input | 1 | Layer enable |
| cfg_clut_on | input | 1 | Colour table enable for indexed pixels |
| cfg_fmt | input | 3 | Pixel format code |
| cfg_alpha | input | 8 | Constant alpha, 0xFF means 1.0 |
| cfg_f1_sel | input | 3 | Layer blend factor code |
| cfg_f2_sel | input | 3 | Lower blend factor code |
| win_x_lo | input | X_W | First horizontal counter value of the window |
| win_x_hi | input | X_W | Last horizontal counter value of the window |
| win_y_lo | input | Y_W | First vertical counter value of the window |
| win_y_hi | input | Y_W | Last vertical counter value of the window |
| tbl_wr | input | 1 | Colour table write strobe |
| tbl_word | input | 32 | Colour table write word (index and RGB) |
| pix_valid | input | 1 | Input pixel valid |
| pos_x | input | X_W | Horizontal counter position |
| pos_y | input | Y_W | Vertical counter position |
| layer_pix | input | 32 | Raw layer pixel |
| lower_pix | input | 24 | Lower RGB pixel |
| out_valid | output | 1 | Result valid |
| out_pix | output | 24 | Blended RGB result |

## Verification
The bench walks each window edge, one position inside and one outside the limit on both axes, because an off-by-one compare would move the layer by a pixel and show up as a lower pixel where the layer belongs, or the reverse. The ARGB1555 alpha bit is tried at both values, and the RGB565 and ARGB4444 fields use patterns with their top bits set, so wrong widening shows up as low bits that are zero. A pair of factor codes whose sum goes above one drives a channel into saturation, where a design without clamping would wrap to a small value. Indexed pixels are read with the colour table on and off, which catches a swapped index field or a table that is ignored.

// File: rtl/lwb_pkg.sv
package lwb_pkg;
  localparam logic [2:0] FMT_ARGB8888 = 3'd0;
  localparam logic [2:0] FMT_RGB888   = 3'd1;
  localparam logic [2:0] FMT_RGB565   = 3'd2;
  localparam logic [2:0] FMT_ARGB1555 = 3'd3;
  localparam logic [2:0] FMT_ARGB4444 = 3'd4;
  localparam logic [2:0] FMT_IDX8     = 3'd5;

  localparam logic [2:0] F1_PA_CA     = 3'd6;
  localparam logic [2:0] F2_INV_PA_CA = 3'd7;

  typedef struct packed {
    logic [7:0] a;
    logic [7:0] r;
    logic [7:0] g;
    logic [7:0] b;
  } argb_t;
endpackage

// File: rtl/lwb_clut.sv
module lwb_clut #(
  parameter int AW = 8,
  parameter int DW = 24
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/lwb_decode.sv
module lwb_decode
  import lwb_pkg::*;
(
  input  logic [2:0]  fmt,
  input  logic [31:0] pix,
  input  logic        clut_on,
  input  logic [23:0] clut_rgb,
  output argb_t       px
);
  always_comb begin
    px = '{a: pix[31:24], r: pix[23:16], g: pix[15:8], b: pix[7:0]};
    unique case (fmt)
      FMT_RGB888: px = '{a: 8'hFF, r: pix[23:16], g: pix[15:8], b: pix[7:0]};
      FMT_RGB565: px = '{a: 8'hFF,
                         r: {pix[15:11], pix[15:13]},
                         g: {pix[10:5],  pix[10:9]},
                         b: {pix[4:0],   pix[4:2]}};
      FMT_ARGB1555: px = '{a: {8{pix[15]}},
                           r: {pix[14:10], pix[14:12]},
                           g: {pix[9:5],   pix[9:7]},
                           b: {pix[4:0],   pix[4:2]}};
      FMT_ARGB4444: px = '{a: {2{pix[15:12]}}, r: {2{pix[11:8]}},
                           g: {2{pix[7:4]}},   b: {2{pix[3:0]}}};
      FMT_IDX8: begin
        if (clut_on) px = '{a: 8'hFF, r: clut_rgb[23:16], g: clut_rgb[15:8], b: clut_rgb[7:0]};
        else         px = '{a: 8'hFF, r: pix[7:0], g: pix[7:0], b: pix[7:0]};
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/lwb_mix.sv
module lwb_mix (
  input  logic [7:0] f1,
  input  logic [7:0] f2,
  input  logic [7:0] top,
  input  logic [7:0] bot,
  output logic [7:0] res
);
  logic [17:0] acc;
  logic [17:0] quo;

  always_comb begin
    acc = 18'(f1) * 18'(top) + 18'(f2) * 18'(bot) + 18'd127;
    quo = acc / 18'd255;
    res = (quo > 18'd255) ? 8'hFF : quo[7:0];
  end
endmodule

// File: rtl/lwb_top.sv
module lwb_top
  import lwb_pkg::*;
#(
  parameter int X_W = 12,
  parameter int Y_W = 11,
  parameter int TBL_AW = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           cfg_layer_on,
  input  logic           cfg_clut_on,
  input  logic [2:0]     cfg_fmt,
  input  logic [7:0]     cfg_alpha,
  input  logic [2:0]     cfg_f1_sel,
  input  logic [2:0]     cfg_f2_sel,
  input  logic [X_W-1:0] win_x_lo,
  input  logic [X_W-1:0] win_x_hi,
  input  logic [Y_W-1:0] win_y_lo,
  input  logic [Y_W-1:0] win_y_hi,
  input  logic           tbl_wr,
  input  logic [31:0]    tbl_word,
  input  logic           pix_valid,
  input  logic [X_W-1:0] pos_x,
  input  logic [Y_W-1:0] pos_y,
  input  logic [31:0]    layer_pix,
  input  logic [23:0]    lower_pix,
  output logic           out_valid,
  output logic [23:0]    out_pix
);
  localparam int CH = 3;

  // stage 1: window decision and colour table read
  logic        s1_valid, s1_apply, s1_clut;
  logic [2:0]  s1_fmt;
  logic [31:0] s1_pix;
  logic [23:0] s1_low;
  logic [23:0] tbl_q;
  logic        in_win;

  assign in_win = (pos_x >= win_x_lo) && (pos_x <= win_x_hi) &&
                  (pos_y >= win_y_lo) && (pos_y <= win_y_hi);

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
      s1_apply <= 1'b0;
      s1_clut  <= 1'b0;
      s1_fmt   <= '0;
      s1_pix   <= '0;
      s1_low   <= '0;
    end else begin
      s1_valid <= pix_valid;
      s1_apply <= cfg_layer_on && in_win;
      s1_clut  <= cfg_clut_on;
      s1_fmt   <= cfg_fmt;
      s1_pix   <= layer_pix;
      s1_low   <= lower_pix;
    end
  end

  lwb_clut #(.AW(TBL_AW), .DW(24)) u_clut (
    .clk   (clk),
    .we    (tbl_wr),
    .waddr (tbl_word[24 +: TBL_AW]),
    .wdata (tbl_word[23:0]),
    .raddr (layer_pix[TBL_AW-1:0]),
    .rdata (tbl_q)
  );

  // stage 2: decode, factors, mix
  argb_t       dec;
  logic [16:0] pa_ca;
  logic [7:0]  paca8, f1, f2;
  logic [23:0] mixed;
  logic [23:0] layer_rgb;

  lwb_decode u_dec (
    .fmt      (s1_fmt),
    .pix      (s1_pix),
    .clut_on  (s1_clut),
    .clut_rgb (tbl_q),
    .px       (dec)
  );

  always_comb begin
    pa_ca = (17'(dec.a) * 17'(cfg_alpha) + 17'd127) / 17'd255;
    paca8 = pa_ca[7:0];
    f1    = (cfg_f1_sel == F1_PA_CA)     ? paca8          : cfg_alpha;
    f2    = (cfg_f2_sel == F2_INV_PA_CA) ? 8'hFF - paca8  : 8'hFF - cfg_alpha;
  end

  assign layer_rgb = {dec.r, dec.g, dec.b};

  for (genvar c = 0; c < CH; c++) begin : g_ch
    lwb_mix u_mix (
      .f1  (f1),
      .f2  (f2),
      .top (layer_rgb[8*c +: 8]),
      .bot (s1_low[8*c +: 8]),
      .res (mixed[8*c +: 8])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_pix   <= '0;
    end else begin
      out_valid <= s1_valid;
      if (s1_valid) out_pix <= s1_apply ? mixed : s1_low;
    end
  end
endmodule

// File: rtl/lwb_checks.sv
module lwb_checks #(
  parameter int X_W = 12,
  parameter int Y_W = 11
) (
  input logic           clk,
  input logic           rst,
  input logic           cfg_layer_on,
  input logic [X_W-1:0] win_x_lo,
  input logic [X_W-1:0] win_x_hi,
  input logic [Y_W-1:0] win_y_lo,
  input logic [Y_W-1:0] win_y_hi,
  input logic           pix_valid,
  input logic [X_W-1:0] pos_x,
  input logic [Y_W-1:0] pos_y,
  input logic [23:0]    lower_pix,
  input logic           out_valid,
  input logic [23:0]    out_pix
);
  logic [1:0] age;
  logic       outside;

  always_ff @(posedge clk) begin
    if (rst) age <= 2'd0;
    else if (age != 2'd2) age <= age + 2'd1;
  end

  assign outside = (pos_x < win_x_lo) || (pos_x > win_x_hi) ||
                   (pos_y < win_y_lo) || (pos_y > win_y_hi);

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (!out_valid && out_pix == 24'd0));

  assert_latency_R2: assert property (@(posedge clk) disable iff (rst)
    (age == 2'd2) |-> (out_valid == $past(pix_valid, 2)));

  assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (age != 2'd0 && !out_valid) |-> $stable(out_pix));

  assert_layer_off_R3: assert property (@(posedge clk) disable iff (rst)
    (age == 2'd2 && $past(pix_valid && !cfg_layer_on, 2)) |-> (out_pix == $past(lower_pix, 2)));

  assert_outside_win_R4: assert property (@(posedge clk) disable iff (rst)
    (age == 2'd2 && $past(pix_valid && outside, 2)) |-> (out_pix == $past(lower_pix, 2)));
endmodule

bind lwb_top lwb_checks #(.X_W(X_W), .Y_W(Y_W)) u_checks (
  .clk          (clk),
  .rst          (rst),
  .cfg_layer_on (cfg_layer_on),
  .win_x_lo     (win_x_lo),
  .win_x_hi     (win_x_hi),
  .win_y_lo     (win_y_lo),
  .win_y_hi     (win_y_hi),
  .pix_valid    (pix_valid),
  .pos_x        (pos_x),
  .pos_y        (pos_y),
  .lower_pix    (lower_pix),
  .out_valid    (out_valid),
  .out_pix      (out_pix)
);

// File: tb/tb_lwb_top.sv
module tb_lwb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_layer_on = 1'b0, cfg_clut_on = 1'b0;
  logic [2:0]  cfg_fmt = 3'd0, cfg_f1_sel = 3'd4, cfg_f2_sel = 3'd5;
  logic [7:0]  cfg_alpha = 8'hFF;
  logic [11:0] win_x_lo = 12'd0, win_x_hi = 12'd4095;
  logic [10:0] win_y_lo = 11'd0, win_y_hi = 11'd2047;
  logic        tbl_wr = 1'b0;
  logic [31:0] tbl_word = '0;
  logic        pix_valid = 1'b0;
  logic [11:0] pos_x = '0;
  logic [10:0] pos_y = '0;
  logic [31:0] layer_pix = '0;
  logic [23:0] lower_pix = '0;
  logic        out_valid;
  logic [23:0] out_pix;

  int tests = 0, fails = 0;
  bit done = 0;
  logic [23:0] exp_q[$];
  string       tag_q[$];
  logic [23:0] tlut [256];

  always #5 clk = ~clk;

  lwb_top dut (.*);

  function automatic logic [7:0] rdiv(input int v);
    int q = (v + 127) / 255;
    return (q > 255) ? 8'hFF : q[7:0];
  endfunction

  function automatic logic [31:0] model_dec(input logic [31:0] p);
    logic [7:0] a, r, g, b;
    case (cfg_fmt)
      3'd1: begin a = 8'hFF; r = p[23:16]; g = p[15:8]; b = p[7:0]; end
      3'd2: begin a = 8'hFF; r = {p[15:11], p[15:13]}; g = {p[10:5], p[10:9]}; b = {p[4:0], p[4:2]}; end
      3'd3: begin a = p[15] ? 8'hFF : 8'h00; r = {p[14:10], p[14:12]}; g = {p[9:5], p[9:7]}; b = {p[4:0], p[4:2]}; end
      3'd4: begin a = {p[15:12], p[15:12]}; r = {p[11:8], p[11:8]}; g = {p[7:4], p[7:4]}; b = {p[3:0], p[3:0]}; end
      3'd5: begin
        a = 8'hFF;
        if (cfg_clut_on) {r, g, b} = tlut[p[7:0]];
        else begin r = p[7:0]; g = p[7:0]; b = p[7:0]; end
      end
      default: begin a = p[31:24]; r = p[23:16]; g = p[15:8]; b = p[7:0]; end
    endcase
    return {a, r, g, b};
  endfunction

  function automatic logic [23:0] model(input logic [11:0] x, input logic [10:0] y,
                                        input logic [31:0] p, input logic [23:0] lo);
    logic [31:0] d;
    int paca, f1, f2;
    logic [23:0] res;
    if (!cfg_layer_on || x < win_x_lo || x > win_x_hi || y < win_y_lo || y > win_y_hi)
      return lo;
    d = model_dec(p);
    paca = int'(rdiv(int'(d[31:24]) * int'(cfg_alpha)));
    f1 = (cfg_f1_sel == 3'd6) ? paca : int'(cfg_alpha);
    f2 = (cfg_f2_sel == 3'd7) ? 255 - paca : 255 - int'(cfg_alpha);
    for (int c = 0; c < 3; c++)
      res[8*c +: 8] = rdiv(f1 * int'(d[8*c +: 8]) + f2 * int'(lo[8*c +: 8]));
    return res;
  endfunction

  task automatic check(input bit ok, input string req, input logic [23:0] act, input logic [23:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%06h expected=%06h", req, act, exp);
    end
  endtask

  task automatic px(input logic [11:0] x, input logic [10:0] y, input logic [31:0] p,
                    input logic [23:0] lo, input string tag);
    @(negedge clk);
    pix_valid = 1'b1; pos_x = x; pos_y = y; layer_pix = p; lower_pix = lo;
    exp_q.push_back(model(x, y, p, lo));
    tag_q.push_back(tag);
  endtask

  task automatic drain();
    @(negedge clk);
    pix_valid = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic tbl_load(input logic [7:0] idx, input logic [23:0] rgb);
    @(negedge clk);
    tbl_wr = 1'b1; tbl_word = {idx, rgb};
    tlut[idx] = rgb;
    @(negedge clk);
    tbl_wr = 1'b0;
  endtask

  // monitor / scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && out_valid) begin
        if (exp_q.size() == 0) check(1'b0, "R2 unexpected result", out_pix, 24'h0);
        else begin
          logic [23:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(out_pix === e, t, out_pix, e);
        end
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check(out_valid === 1'b0, "R1 out_valid in reset", {23'd0, out_valid}, 24'd0);
    check(out_pix === 24'd0, "R1 out_pix in reset", out_pix, 24'd0);
    rst = 1'b0;

    // R3: layer off passes lower pixel
    cfg_layer_on = 1'b0;
    px(12'd50, 11'd50, 32'hFF123456, 24'hA1B2C3, "R3 layer off");
    px(12'd51, 11'd50, 32'h00FFFFFF, 24'h0F0E0D, "R3 layer off");
    drain();

    // R2: two-edge latency observed at the port
    @(negedge clk);
    pix_valid = 1'b1; pos_x = 12'd1; pos_y = 11'd1; layer_pix = 32'h0; lower_pix = 24'h445566;
    exp_q.push_back(24'h445566); tag_q.push_back("R2 latency data");
    @(negedge clk);
    pix_valid = 1'b0;
    check(out_valid === 1'b0, "R2 not valid after one edge", {23'd0, out_valid}, 24'd0);
    @(negedge clk);
    check(out_valid === 1'b1, "R2 valid after two edges", {23'd0, out_valid}, 24'd1);
    repeat (3) @(negedge clk);
    check(out_pix === 24'h445566, "R2 hold while idle", out_pix, 24'h445566);

    // R10 / R5 opaque RGB888
    cfg_layer_on = 1'b1; cfg_fmt = 3'd1; cfg_alpha = 8'hFF; cfg_f1_sel = 3'd4; cfg_f2_sel = 3'd5;
    px(12'd5, 11'd5, 32'h00ABCDEF, 24'h112233, "R10 opaque RGB888");
    drain();

    // R4 window edges
    win_x_lo = 12'd10; win_x_hi = 12'd20; win_y_lo = 11'd5; win_y_hi = 11'd8;
    px(12'd9,  11'd6, 32'h00FFFFFF, 24'h010203, "R4 left of window");
    px(12'd10, 11'd6, 32'h00FFFFFF, 24'h010203, "R4 first column");
    px(12'd20, 11'd6, 32'h00FFFFFF, 24'h010203, "R4 last column");
    px(12'd21, 11'd6, 32'h00FFFFFF, 24'h010203, "R4 right of window");
    px(12'd15, 11'd4, 32'h00FFFFFF, 24'h010203, "R4 above window");
    px(12'd15, 11'd5, 32'h00FFFFFF, 24'h010203, "R4 first line");
    px(12'd15, 11'd8, 32'h00FFFFFF, 24'h010203, "R4 last line");
    px(12'd15, 11'd9, 32'h00FFFFFF, 24'h010203, "R4 below window");
    drain();
    win_x_lo = 12'd0; win_x_hi = 12'd4095; win_y_lo = 11'd0; win_y_hi = 11'd2047;

    // R7 R8 R9 pixel alpha times constant alpha
    cfg_fmt = 3'd0; cfg_alpha = 8'h80; cfg_f1_sel = 3'd6; cfg_f2_sel = 3'd7;
    px(12'd3, 11'd3, 32'hFF804020, 24'h204080, "R7 R8 PA*CA alpha FF");
    px(12'd3, 11'd3, 32'h40F0F0F0, 24'h101010, "R7 R8 PA*CA alpha 40");
    px(12'd3, 11'd3, 32'h00FFFFFF, 24'h123456, "R9 zero pixel alpha");
    drain();
    cfg_f1_sel = 3'd4; cfg_f2_sel = 3'd5; cfg_alpha = 8'h33;
    px(12'd3, 11'd3, 32'h00C0A080, 24'h406080, "R7 R8 constant alpha");
    drain();

    // R9 saturation: F1 = CA, F2 = 1 - PA*CA with PA = 0
    cfg_alpha = 8'hFF; cfg_f1_sel = 3'd4; cfg_f2_sel = 3'd7;
    px(12'd3, 11'd3, 32'h00C8C8C8, 24'hC80A64, "R9 saturation");
    drain();

    // R5 narrow formats
    cfg_f1_sel = 3'd6; cfg_f2_sel = 3'd7;
    cfg_fmt = 3'd2;
    px(12'd3, 11'd3, 32'h0000F81F, 24'h000000, "R5 RGB565");
    px(12'd3, 11'd3, 32'h0000A5B4, 24'h000000, "R5 RGB565 mixed");
    drain();
    cfg_fmt = 3'd3;
    px(12'd3, 11'd3, 32'h0000FC1F, 24'h000000, "R5 ARGB1555 alpha 1");
    px(12'd3, 11'd3, 32'h00007C00, 24'h5A5A5A, "R5 ARGB1555 alpha 0");
    drain();
    cfg_fmt = 3'd4;
    px(12'd3, 11'd3, 32'h00009C3F, 24'h808080, "R5 ARGB4444");
    drain();
    cfg_fmt = 3'd7;
    px(12'd3, 11'd3, 32'hFF13579B, 24'h000000, "R5 unlisted code as ARGB8888");
    drain();

    // R6 indexed with and without table
    tbl_load(8'h03, 24'h112233);
    tbl_load(8'h80, 24'hF00D0F);
    tbl_load(8'hFF, 24'h0A0B0C);
    cfg_fmt = 3'd5; cfg_clut_on = 1'b1; cfg_f1_sel = 3'd4; cfg_f2_sel = 3'd5;
    px(12'd3, 11'd3, 32'h00000003, 24'h000000, "R6 table entry 03");
    px(12'd3, 11'd3, 32'h00000080, 24'h000000, "R6 table entry 80");
    px(12'd3, 11'd3, 32'hAB0000FF, 24'h000000, "R6 table entry FF");
    drain();
    cfg_clut_on = 1'b0;
    px(12'd3, 11'd3, 32'h00000080, 24'h000000, "R6 table off grey");
    drain();

    check(exp_q.size() == 0, "R2 all results delivered", 24'(exp_q.size()), 24'd0);
    finish_run();
  end
endmodule